// File: doc/BRIEF.md
# Serial Latched Configuration Port

This block is a write-only configuration slave driven by three serial pins: a shift clock, a data line and a latch strobe. A host shifts a 24-bit frame into it, most significant bit first, and then pulses the latch. The three bits at the bottom of the frame pick one of eight internal words, and the frame is stored there whole. The stored words are decoded into configuration fields for the rest of the device. These fields cover the two synthesiser dividers and reference dividers, prescaler selects, charge-pump controls, lock-detect options, transmit gain and mode, receive mode, attenuator control and the power-control code.

The serial pins are asynchronous to the core clock. They pass through a synchroniser, and a frame is committed on the detected falling edge of the latch. A frame whose latch arrives after any count of shift clocks other than 24 is dropped, and an error flag is raised. One bit of the transmit-control word requests a filter calibration. An external calibration engine returns its 4-bit result over a valid/ready channel. The block accepts the result only while the request bit is set. Acceptance writes the result into the same word, clears the request bit and marks the result as valid. The engine must hold valid and the code stable until it sees ready; a beat offered while ready is low is not taken.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset (rst_n low) every decoded field, `cal_start`, `cal_ok`, `frame_err` and `cal_res_ready` read 0.
- R2: A frame is 24 bits shifted most significant bit first, sampled on rising `ser_clk` edges while `ser_lat` is low. It is committed on the falling edge of `ser_lat` into the word numbered by frame bits 2:0 (0 to 7).
- R3: Word 0 gives `rx_div_m` = bits 20:10 and `rx_div_a` = bits 9:3. Word 1 gives `tx_div_m` and `tx_div_a` from the same positions.
- R4: Word 2 gives `rx_ref_div` = bits 17:3, `rx_lock_inv` = bit 18 and `tx_lock_inv` = bit 19. Word 3 gives `tx_ref_div` = bits 17:3 and `tx_pump_inv` = bit 18.
- R5: Word 4 gives:
  - `rx_pump_inv` = bit 20
  - `tx_psc_sel` = bits 17:15
  - `rx_psc_sel` = bits 14:12
  - `rx_pump_hiz` = bit 11
  - `tx_pump_hiz` = bit 10
  - `tx_pump_cur` = bits 9:8
  - `rx_pump_cur` = bits 7:6
  - `lock_src_tx` = bit 5
- R6: Word 5 gives `tx_gain_sel` = bits 13:11, `cal_start` = bit 10, `tx_mode_sel` = bits 9:8 and `cal_result` = bits 6:3. Word 6 gives `pwr_code` = bits 17:15, `atten_manual` = bit 12, `rx_fm_mode` = bit 11 and `rx_ctl` = bits 9:6.
- R7: A frame to word 7 is accepted (no error) and changes no output.
- R8: Rising `ser_clk` edges while `ser_lat` is high are ignored; they neither shift data nor count toward the 24.
- R9: A latch that follows any count of clocks other than 24 leaves every word unchanged and sets `frame_err`. The next good frame clears `frame_err`.
- R10: `cal_res_ready` is high while word 5 bit 10 is set, except in a cycle that commits a frame. A beat with `cal_res_valid` and `cal_res_ready` both high writes `cal_res_code` into word 5 bits 6:3, clears bit 10 and sets `cal_ok`; the other word 5 fields keep their values.
- R11: A `cal_res_valid` beat while `cal_res_ready` is low changes no output.
- R12: Any committed frame to word 5 clears `cal_ok`, and `cal_result` takes the written bits 6:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data |
| ser_lat | input | 1 | Latch strobe, low outside the commit pulse |
| cal_res_valid | input | 1 | Calibration result offered |
| cal_res_ready | output | 1 | Calibration result can be taken |
| cal_res_code | input | 4 | Calibration result code |
| frame_err | output | 1 | Last latch followed a wrong clock count |
| rx_div_m | output | 11 | Receive divider M |
| rx_div_a | output | 7 | Receive divider A |
| tx_div_m | output | 11 | Transmit divider M |
| tx_div_a | output | 7 | Transmit divider A |
| rx_ref_div | output | 15 | Receive reference divider |
| tx_ref_div | output | 15 | Transmit reference divider |
| rx_lock_inv | output | 1 | Receive lock-detect invert |
| tx_lock_inv | output | 1 | Transmit lock-detect invert |
| rx_pump_inv | output | 1 | Receive pump polarity |
| tx_pump_inv | output | 1 | Transmit pump polarity |
| rx_psc_sel | output | 3 | Receive prescaler select |
| tx_psc_sel | output | 3 | Transmit prescaler select |
| rx_pump_hiz | output | 1 | Receive pump high impedance |
| tx_pump_hiz | output | 1 | Transmit pump high impedance |
| rx_pump_cur | output | 2 | Receive pump current select |
| tx_pump_cur | output | 2 | Transmit pump current select |
| lock_src_tx | output | 1 | Lock-detect source is transmit loop |
| tx_gain_sel | output | 3 | Transmit gain select |
| tx_mode_sel | output | 2 | Transmit mode select |
| cal_start | output | 1 | Calibration requested |
| cal_result | output | 4 | Stored calibration code |
| cal_ok | output | 1 | Stored code came from a calibration |
| pwr_code | output | 3 | Power-control code |
| rx_fm_mode | output | 1 | Receive discriminator mode |
| atten_manual | output | 1 | Manual input attenuator |
| rx_ctl | output | 4 | Receive control bits |

## Verification
Any misdecoded bit counter or stale shift register shows up on the field ports a few core cycles after the latch falls. Such a fault either lands a good frame in the wrong field or word, or raises `frame_err` where none should be. A calibration handshake that is wrong appears on the next accepted or refused beat, through `cal_start`, `cal_result` and `cal_ok`. A fault that lets a refused or malformed transfer disturb state is caught by comparing every field against a shadow copy after each frame.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  localparam int WORD_W    = 24;
  localparam int ADDR_W    = 3;
  localparam int NUM_WORDS = 1 << ADDR_W;
  localparam int DIV_M_W   = 11;
  localparam int DIV_A_W   = 7;
  localparam int REF_W     = 15;
  localparam int CAL_W     = 4;
  localparam int CNT_W     = $clog2(WORD_W + 2);

  localparam int W_RXDIV = 0;
  localparam int W_TXDIV = 1;
  localparam int W_RXREF = 2;
  localparam int W_TXREF = 3;
  localparam int W_PUMP  = 4;
  localparam int W_TXCTL = 5;
  localparam int W_RXCTL = 6;

  localparam int DIV_A_LSB   = 3;
  localparam int DIV_M_LSB   = DIV_A_LSB + DIV_A_W;
  localparam int REF_LSB     = 3;
  localparam int CAL_GO_BIT  = 10;
  localparam int CAL_RES_LSB = 3;

  typedef logic [WORD_W-1:0] frame_t;
  typedef logic [ADDR_W-1:0] waddr_t;
endpackage

// File: rtl/cfgs_sync.sv
module cfgs_sync #(
  parameter int N_BITS = 3,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_BITS-1:0] d,
  output logic [N_BITS-1:0] q
);
  logic [STAGES-1:0][N_BITS-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgs_deser.sv
module cfgs_deser
  import cfgs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclk_s,
  input  logic   sdat_s,
  input  logic   slat_s,
  output logic   wr_en,
  output waddr_t wr_addr,
  output frame_t wr_data,
  output logic   frame_err
);
  logic             sclk_d, slat_d;
  logic             clk_rise, lat_fall;
  logic [CNT_W-1:0] cnt;
  frame_t           shreg;

  assign clk_rise = sclk_s & ~sclk_d;
  assign lat_fall = slat_d & ~slat_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      slat_d    <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      wr_en     <= 1'b0;
      wr_data   <= '0;
      frame_err <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      slat_d <= slat_s;
      wr_en  <= 1'b0;
      if (lat_fall) begin
        cnt <= '0;
        if (cnt == CNT_W'(WORD_W)) begin
          wr_en     <= 1'b1;
          wr_data   <= shreg;
          frame_err <= 1'b0;
        end else begin
          frame_err <= 1'b1;
        end
      end else if (clk_rise && !slat_s) begin
        shreg <= {shreg[WORD_W-2:0], sdat_s};
        if (cnt != CNT_W'(WORD_W + 1)) cnt <= cnt + 1'b1;
      end
    end
  end

  assign wr_addr = wr_data[ADDR_W-1:0];

  assert_latch_freezes_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slat_s |=> $stable(shreg));
  assert_err_only_on_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> $past(lat_fall));
  assert_commit_needs_full_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_fall && cnt != CNT_W'(WORD_W)) |=> !wr_en && frame_err);
endmodule

// File: rtl/cfgs_regfile.sv
module cfgs_regfile
  import cfgs_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  waddr_t                           wr_addr,
  input  frame_t                           wr_data,
  input  logic                             cal_valid,
  output logic                             cal_ready,
  input  logic [CAL_W-1:0]                 cal_code,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] regs_o,
  output logic                             cal_ok
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] regs_q;
  logic cal_acc, cal_wr;

  assign cal_ready = regs_q[W_TXCTL][CAL_GO_BIT] & ~wr_en;
  assign cal_acc   = cal_valid & cal_ready;
  assign cal_wr    = wr_en && (wr_addr == ADDR_W'(W_TXCTL));

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[i] <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(i)) begin
        regs_q[i] <= wr_data;
      end else if (i == W_TXCTL && cal_acc) begin
        regs_q[i][CAL_GO_BIT]               <= 1'b0;
        regs_q[i][CAL_RES_LSB +: CAL_W]     <= cal_code;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cal_ok <= 1'b0;
    else if (cal_wr)  cal_ok <= 1'b0;
    else if (cal_acc) cal_ok <= 1'b1;
  end

  assign regs_o = regs_q;

  assert_frame_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs_q[$past(wr_addr)] == $past(wr_data));
  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !cal_acc) |=> $stable(regs_q));
  assert_cal_completes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cal_acc |=> !regs_q[W_TXCTL][CAL_GO_BIT] && cal_ok
                && regs_q[W_TXCTL][CAL_RES_LSB +: CAL_W] == $past(cal_code));
  assert_write_invalidates_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cal_wr |=> !cal_ok);
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfgs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_dat,
  input  logic               ser_lat,
  input  logic               cal_res_valid,
  output logic               cal_res_ready,
  input  logic [CAL_W-1:0]   cal_res_code,
  output logic               frame_err,
  output logic [DIV_M_W-1:0] rx_div_m,
  output logic [DIV_A_W-1:0] rx_div_a,
  output logic [DIV_M_W-1:0] tx_div_m,
  output logic [DIV_A_W-1:0] tx_div_a,
  output logic [REF_W-1:0]   rx_ref_div,
  output logic [REF_W-1:0]   tx_ref_div,
  output logic               rx_lock_inv,
  output logic               tx_lock_inv,
  output logic               rx_pump_inv,
  output logic               tx_pump_inv,
  output logic [2:0]         rx_psc_sel,
  output logic [2:0]         tx_psc_sel,
  output logic               rx_pump_hiz,
  output logic               tx_pump_hiz,
  output logic [1:0]         rx_pump_cur,
  output logic [1:0]         tx_pump_cur,
  output logic               lock_src_tx,
  output logic [2:0]         tx_gain_sel,
  output logic [1:0]         tx_mode_sel,
  output logic               cal_start,
  output logic [CAL_W-1:0]   cal_result,
  output logic               cal_ok,
  output logic [2:0]         pwr_code,
  output logic               rx_fm_mode,
  output logic               atten_manual,
  output logic [3:0]         rx_ctl
);
  logic [2:0] pins_s;
  logic       wr_en;
  waddr_t     wr_addr;
  frame_t     wr_data;
  logic [NUM_WORDS-1:0][WORD_W-1:0] regs;
  logic       unused_fold;

  cfgs_sync #(.N_BITS(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_lat, ser_dat, ser_clk}), .q(pins_s)
  );

  cfgs_deser u_deser (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[0]), .sdat_s(pins_s[1]), .slat_s(pins_s[2]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .frame_err(frame_err)
  );

  cfgs_regfile u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cal_valid(cal_res_valid), .cal_ready(cal_res_ready), .cal_code(cal_res_code),
    .regs_o(regs), .cal_ok(cal_ok)
  );

  assign rx_div_m     = regs[W_RXDIV][DIV_M_LSB +: DIV_M_W];
  assign rx_div_a     = regs[W_RXDIV][DIV_A_LSB +: DIV_A_W];
  assign tx_div_m     = regs[W_TXDIV][DIV_M_LSB +: DIV_M_W];
  assign tx_div_a     = regs[W_TXDIV][DIV_A_LSB +: DIV_A_W];

  assign rx_ref_div   = regs[W_RXREF][REF_LSB +: REF_W];
  assign rx_lock_inv  = regs[W_RXREF][REF_LSB + REF_W];
  assign tx_lock_inv  = regs[W_RXREF][REF_LSB + REF_W + 1];
  assign tx_ref_div   = regs[W_TXREF][REF_LSB +: REF_W];
  assign tx_pump_inv  = regs[W_TXREF][REF_LSB + REF_W];

  assign rx_pump_inv  = regs[W_PUMP][20];
  assign tx_psc_sel   = regs[W_PUMP][17:15];
  assign rx_psc_sel   = regs[W_PUMP][14:12];
  assign rx_pump_hiz  = regs[W_PUMP][11];
  assign tx_pump_hiz  = regs[W_PUMP][10];
  assign tx_pump_cur  = regs[W_PUMP][9:8];
  assign rx_pump_cur  = regs[W_PUMP][7:6];
  assign lock_src_tx  = regs[W_PUMP][5];

  assign tx_gain_sel  = regs[W_TXCTL][13:11];
  assign cal_start    = regs[W_TXCTL][CAL_GO_BIT];
  assign tx_mode_sel  = regs[W_TXCTL][9:8];
  assign cal_result   = regs[W_TXCTL][CAL_RES_LSB +: CAL_W];

  assign pwr_code     = regs[W_RXCTL][17:15];
  assign atten_manual = regs[W_RXCTL][12];
  assign rx_fm_mode   = regs[W_RXCTL][11];
  assign rx_ctl       = regs[W_RXCTL][9:6];

  assign unused_fold  = ^regs;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !cal_ok && !frame_err && !cal_start);
endmodule

// File: tb/tb_cfg_serial_port.sv
module tb_cfg_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 4;

  logic clk = 0, rst_n = 0, ser_clk = 0, ser_dat = 0, ser_lat = 0;
  logic cal_res_valid = 0;
  logic [3:0] cal_res_code = 0;
  logic cal_res_ready, frame_err, rx_lock_inv, tx_lock_inv, rx_pump_inv, tx_pump_inv;
  logic rx_pump_hiz, tx_pump_hiz, lock_src_tx, cal_start, cal_ok, rx_fm_mode, atten_manual;
  logic [10:0] rx_div_m, tx_div_m;
  logic [6:0] rx_div_a, tx_div_a;
  logic [14:0] rx_ref_div, tx_ref_div;
  logic [2:0] rx_psc_sel, tx_psc_sel, tx_gain_sel, pwr_code;
  logic [1:0] rx_pump_cur, tx_pump_cur, tx_mode_sel;
  logic [3:0] cal_result, rx_ctl;

  int checks = 0, fails = 0;
  logic [23:0] shw [8];
  logic exp_ok = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_port dut (.*);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    chk({"R3 rx_div_m ", ctx}, 32'(rx_div_m), 32'(shw[0][20:10]));
    chk({"R3 rx_div_a ", ctx}, 32'(rx_div_a), 32'(shw[0][9:3]));
    chk({"R3 tx_div_m ", ctx}, 32'(tx_div_m), 32'(shw[1][20:10]));
    chk({"R3 tx_div_a ", ctx}, 32'(tx_div_a), 32'(shw[1][9:3]));
    chk({"R4 rx_ref ", ctx}, 32'(rx_ref_div), 32'(shw[2][17:3]));
    chk({"R4 lock_inv ", ctx}, 32'({tx_lock_inv, rx_lock_inv}), 32'(shw[2][19:18]));
    chk({"R4 tx_ref ", ctx}, 32'(tx_ref_div), 32'(shw[3][17:3]));
    chk({"R4 tx_pump_inv ", ctx}, 32'(tx_pump_inv), 32'(shw[3][18]));
    chk({"R5 pump word ", ctx},
        32'({rx_pump_inv, tx_psc_sel, rx_psc_sel, rx_pump_hiz, tx_pump_hiz,
             tx_pump_cur, rx_pump_cur, lock_src_tx}),
        32'({shw[4][20], shw[4][17:5]}));
    chk({"R6 tx ctl ", ctx}, 32'({tx_gain_sel, cal_start, tx_mode_sel}), 32'(shw[5][13:8]));
    chk({"R6 cal_result ", ctx}, 32'(cal_result), 32'(shw[5][6:3]));
    chk({"R6 rx ctl ", ctx}, 32'({pwr_code, atten_manual, rx_fm_mode, rx_ctl}),
        32'({shw[6][17:15], shw[6][12:11], shw[6][9:6]}));
    chk({"R12 cal_ok ", ctx}, 32'(cal_ok), 32'(exp_ok));
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int b = n - 1; b >= 0; b--) begin
      ser_dat = v[b];
      tick(HP);
      ser_clk = 1;
      tick(HP);
      ser_clk = 0;
    end
  endtask

  task automatic pulse_latch();
    tick(HP);
    ser_lat = 1;
    tick(2 * HP);
    ser_lat = 0;
    tick(10);
  endtask

  task automatic send_good(input logic [23:0] f);
    shift_bits(32'(f), 24);
    pulse_latch();
    shw[f[2:0]] = f;
    if (f[2:0] == 3'd5) exp_ok = 0;
  endtask

  function automatic logic [23:0] mk(input int a, input int p);
    logic [20:0] d;
    d = 21'(a * 32'h9E3779 + p * 32'h5A5A5 + 32'h13579 + p * p * 32'h1C3);
    if (a == 5) d[7] = 1'b0;
    return {d, 3'(a)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) shw[i] = '0;
    tick(5);
    rst_n = 1;
    tick(3);
    // R1: reset state
    check_all("R1 reset");
    chk("R1 frame_err", 32'(frame_err), 0);
    chk("R1 cal_res_ready", 32'(cal_res_ready), 0);

    // R2..R7 sweep every word with several patterns
    for (int p = 0; p < 3; p++) begin
      for (int a = 0; a < 8; a++) begin
        send_good(mk(a, p));
        check_all($sformatf("R2 sweep a=%0d p=%0d", a, p));
        chk("R7/R2 no error", 32'(frame_err), 0);
      end
    end
    // all ones and all zeros into word 4 (R5)
    send_good(24'hFFFFFC);
    check_all("R5 ones");
    send_good(24'h000004);
    check_all("R5 zeros");
    // R7: word 7 changes no output
    send_good(24'hABCDEF);
    check_all("R7 test word");

    // R9: wrong clock counts
    foreach (shw[i]) ;
    for (int k = 0; k < 8; k++) begin
      int n;
      n = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 12 : (k == 3) ? 23 :
          (k == 4) ? 25 : (k == 5) ? 26 : (k == 6) ? 31 : 2;
      shift_bits(32'hFFFFFFF9 ^ 32'(k << 8), n);
      pulse_latch();
      chk($sformatf("R9 err n=%0d", n), 32'(frame_err), 1);
      check_all($sformatf("R9 unchanged n=%0d", n));
    end
    send_good(mk(6, 7));
    chk("R9 err cleared", 32'(frame_err), 0);
    check_all("R9 recover");

    // R8: clocks while latch high are ignored
    shift_bits(32'(mk(2, 9)), 24);
    tick(HP);
    ser_lat = 1;
    tick(2 * HP);
    for (int t = 0; t < 4; t++) begin
      ser_dat = ~ser_dat;
      tick(HP); ser_clk = 1;
      tick(HP); ser_clk = 0;
    end
    ser_lat = 0;
    tick(10);
    shw[2] = mk(2, 9);
    chk("R8 no error", 32'(frame_err), 0);
    check_all("R8 latch high clocks");

    // R11: beat refused while request bit is clear
    send_good({10'h0, 3'b101, 1'b0, 2'b10, 1'b0, 4'h6, 3'd5});
    cal_res_code = 4'h9;
    cal_res_valid = 1;
    tick(8);
    chk("R11 ready low", 32'(cal_res_ready), 0);
    cal_res_valid = 0;
    tick(2);
    check_all("R11 refused beat");

    // R10: calibration handshake
    send_good({10'h0, 3'b011, 1'b1, 2'b01, 1'b0, 4'h2, 3'd5});
    chk("R10 cal_start", 32'(cal_start), 1);
    chk("R10 ready high", 32'(cal_res_ready), 1);
    cal_res_code = 4'hA;
    cal_res_valid = 1;
    tick(1);
    cal_res_valid = 0;
    cal_res_code = 4'h3;
    tick(2);
    shw[5][10] = 1'b0;
    shw[5][6:3] = 4'hA;
    exp_ok = 1;
    check_all("R10 accepted");
    chk("R10 ready drops", 32'(cal_res_ready), 0);

    // R12: rewrite of word 5 invalidates
    send_good({10'h0, 3'b110, 1'b0, 2'b00, 1'b0, 4'h5, 3'd5});
    check_all("R12 overwrite");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule